// File: doc/BRIEF.md
# Packet-Granular Round-Robin DMA Ring Arbiter

This block shares a single DMA data mover among up to sixteen descriptor rings. Each ring offers one pending transfer at a time as a byte count on a valid/ready pair. The arbiter walks the requesting rings in round-robin order and sends the selected ring's data as 64-byte beats on an output stream. Each beat carries the index of the granted ring. The grant is held for a whole packet, and the last beat of each packet is flagged. Packet length is set per ring, so it acts as a static priority: a ring with long packets keeps the mover longer on each turn than a ring with short packets.

Rings are strapped as compute-class or collective-class. A compute ring takes its packet length from its own register. That length can be raised above 4 KiB but never set below it. A collective ring carries a stream number and takes its packet length from the register of that stream. That length can be lowered from 64 KiB but never set above it. Register writes are clamped to these limits. A new value applies from the next packet that ring starts.

Top module: `pkt_rr_dma_arb`

## Requirements
- R1: When no packet is in progress, the grant goes to the first ring with `desc_valid` high, searching upward from the ring after the last ring served and wrapping at the top ring index. After reset the last ring served is taken to be ring 0.
- R2: `out_ring` does not change between two beats of the same packet. The grant moves only after a beat with `out_last` high has been accepted.
- R3: `out_valid` is high in any cycle where a packet is in progress or any `desc_valid` is high. Rings without a descriptor are skipped in the same cycle, so no empty beat is ever issued. After reset, with no requests, `out_valid` and `desc_ready` are low.
- R4: A compute ring's packet register resets to 4096 bytes (64 beats). A write with `cfg_tgt`=0 and `cfg_idx`=ring sets it to `cfg_bytes`/64 beats, rounded down. The result is raised to at least 64 beats and capped at 1024 beats.
- R5: A stream packet register resets to 65536 bytes (1024 beats). A write with `cfg_tgt`=1 and `cfg_idx`=stream sets it to `cfg_bytes`/64 beats, rounded down. The result is capped at 1024 beats, and a value of 0 is raised to 1 beat.
- R6: A ring with its bit of `ring_coll` high uses the register of the stream given by its 2-bit field of `ring_stream`. A ring with the bit low uses its own compute register.
- R7: A transfer of B bytes moves ceil(B/64) beats. `desc_ready` of that ring pulses together with the accepted final beat of the transfer. If fewer beats remain than the packet length, the packet is shortened to end with the transfer.
- R8: `out_last` is high on the final beat of every packet. Packet length is the lesser of the ring's packet length and the beats remaining in its transfer.
- R9: A packet-register write never changes the length of a packet already in progress. It takes effect when that ring starts its next packet.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_ring` and `out_last` hold their values, and no beat count or grant state moves.
- R11: Two continuously busy rings, one with 4 KiB packets and one with 64 KiB packets, alternate packets and move data in a 1:16 ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| desc_valid | input | 16 | Per-ring transfer pending |
| desc_bytes | input | 384 | Per-ring byte count, 24 bits per ring, ring r at [24r+23:24r] |
| desc_ready | output | 16 | Per-ring transfer completed and consumed |
| ring_coll | input | 16 | Per-ring class: 1 collective, 0 compute |
| ring_stream | input | 32 | Per-ring stream number, 2 bits per ring |
| cfg_we | input | 1 | Packet-register write strobe |
| cfg_tgt | input | 1 | Write target: 0 compute ring register, 1 stream register |
| cfg_idx | input | 4 | Ring or stream index of the write |
| cfg_bytes | input | 20 | Requested packet length in bytes |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Beat accepted by downstream |
| out_last | output | 1 | Final beat of the current packet |
| out_ring | output | 4 | Ring that owns the current beat |

## Verification
The bench goes after the points where a packet ends early or late. These are a transfer tail shorter than the packet, which must raise both `out_last` and `desc_ready` on one beat, and transfers with byte counts that are not multiples of 64. A rounding or minimum error there shows up as a missing or extra beat. Clamp values are probed at both limits for each class, and the bench checks that a collective ring follows its stream's register rather than its own. A design that picked up a write immediately would cut an in-flight packet short, and the bench writes in the middle of a packet to catch this. Random backpressure is applied to catch a grant that drifts while stalled. An arbiter that released the grant in the middle of a packet would break the 1:16 split between a 4 KiB ring and a 64 KiB ring.

// File: rtl/pkt_arb_pkg.sv
package pkt_arb_pkg;
  typedef enum logic {
    CFG_RING   = 1'b0,
    CFG_STREAM = 1'b1
  } cfg_tgt_e;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N_RINGS = 16,
  localparam int IDX_W = $clog2(N_RINGS)
) (
  input  logic [N_RINGS-1:0] req,
  input  logic [IDX_W-1:0]   last_idx,
  output logic               pick_any,
  output logic [IDX_W-1:0]   pick_idx
);
  int cand;

  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    cand     = 0;
    for (int k = 1; k <= N_RINGS; k++) begin
      cand = (int'(last_idx) + k) % N_RINGS;
      if (!pick_any && req[cand]) begin
        pick_any = 1'b1;
        pick_idx = IDX_W'(cand);
      end
    end
    // R1
    pick_hit_chk: assert (!pick_any || req[pick_idx]);
  end
endmodule

// File: rtl/pkt_size_regs.sv
module pkt_size_regs import pkt_arb_pkg::*; #(
  parameter int N_RINGS       = 16,
  parameter int N_STREAMS     = 4,
  parameter int CFG_W         = 20,
  parameter int BEAT_BYTES    = 64,
  parameter int CMP_MIN_BYTES = 4096,
  parameter int PKT_MAX_BYTES = 65536,
  localparam int IDX_W   = $clog2(N_RINGS),
  localparam int STR_W   = $clog2(N_STREAMS),
  localparam int BSH     = $clog2(BEAT_BYTES),
  localparam int MAX_BTS = PKT_MAX_BYTES / BEAT_BYTES,
  localparam int MIN_BTS = CMP_MIN_BYTES / BEAT_BYTES,
  localparam int PKT_W   = $clog2(MAX_BTS + 1),
  localparam int REQ_W   = CFG_W - BSH
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic                           cfg_tgt,
  input  logic [IDX_W-1:0]               cfg_idx,
  input  logic [CFG_W-1:0]               cfg_bytes,
  input  logic [N_RINGS-1:0]             ring_coll,
  input  logic [N_RINGS*STR_W-1:0]       ring_stream,
  output logic [N_RINGS-1:0][PKT_W-1:0]  size_beats
);
  cfg_tgt_e            tgt;
  logic [REQ_W-1:0]    req_beats;
  logic [PKT_W-1:0]    cmp_val;
  logic [PKT_W-1:0]    str_val;
  logic [N_RINGS-1:0][PKT_W-1:0]   cmp_q;
  logic [N_STREAMS-1:0][PKT_W-1:0] str_q;

  assign tgt       = cfg_tgt_e'(cfg_tgt);
  assign req_beats = cfg_bytes[CFG_W-1:BSH];

  always_comb begin
    if (req_beats < REQ_W'(MIN_BTS))      cmp_val = PKT_W'(MIN_BTS);
    else if (req_beats > REQ_W'(MAX_BTS)) cmp_val = PKT_W'(MAX_BTS);
    else                                  cmp_val = req_beats[PKT_W-1:0];
    if (req_beats == '0)                  str_val = PKT_W'(1);
    else if (req_beats > REQ_W'(MAX_BTS)) str_val = PKT_W'(MAX_BTS);
    else                                  str_val = req_beats[PKT_W-1:0];
  end

  for (genvar r = 0; r < N_RINGS; r++) begin : g_cmp
    logic wr_en;
    assign wr_en = cfg_we && (tgt == CFG_RING) && (cfg_idx == IDX_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cmp_q[r] <= PKT_W'(MIN_BTS);
      else if (wr_en) cmp_q[r] <= cmp_val;
    end
    assign size_beats[r] = ring_coll[r] ? str_q[ring_stream[r*STR_W +: STR_W]] : cmp_q[r];
    // R4
    cmp_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_q[r] >= PKT_W'(MIN_BTS) && cmp_q[r] <= PKT_W'(MAX_BTS));
  end

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_str
    logic wr_en;
    assign wr_en = cfg_we && (tgt == CFG_STREAM) && (cfg_idx == IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     str_q[s] <= PKT_W'(MAX_BTS);
      else if (wr_en) str_q[s] <= str_val;
    end
    // R5
    str_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      str_q[s] != '0 && str_q[s] <= PKT_W'(MAX_BTS));
  end
endmodule

// File: rtl/ring_progress.sv
module ring_progress #(
  parameter int N_RINGS    = 16,
  parameter int LEN_W      = 24,
  parameter int BEAT_BYTES = 64,
  localparam int IDX_W = $clog2(N_RINGS),
  localparam int BSH   = $clog2(BEAT_BYTES),
  localparam int REM_W = LEN_W - BSH + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_RINGS-1:0]            desc_valid,
  input  logic [N_RINGS*LEN_W-1:0]      desc_bytes,
  input  logic                          beat_fire,
  input  logic [IDX_W-1:0]              beat_ring,
  output logic [N_RINGS-1:0][REM_W-1:0] rem_beats
);
  for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
    logic [LEN_W:0]     padded;
    logic [REM_W-1:0]   total_b;
    logic [REM_W-1:0]   done_q;
    logic [REM_W-1:0]   done_d;
    logic               hit;

    assign padded       = {1'b0, desc_bytes[r*LEN_W +: LEN_W]} + (LEN_W+1)'(BEAT_BYTES - 1);
    assign total_b      = padded[LEN_W:BSH];
    assign rem_beats[r] = total_b - done_q;
    assign hit          = beat_fire && (beat_ring == IDX_W'(r));

    always_comb begin
      done_d = done_q;
      if (hit) done_d = (rem_beats[r] == REM_W'(1)) ? '0 : done_q + REM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   done_q <= '0;
      else if (hit) done_q <= done_d;
    end

    // R7
    done_within_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid[r] |-> done_q < total_b);
  end
endmodule

// File: rtl/pkt_rr_dma_arb.sv
module pkt_rr_dma_arb #(
  parameter int N_RINGS       = 16,
  parameter int N_STREAMS     = 4,
  parameter int LEN_W         = 24,
  parameter int CFG_W         = 20,
  parameter int BEAT_BYTES    = 64,
  parameter int CMP_MIN_BYTES = 4096,
  parameter int PKT_MAX_BYTES = 65536,
  localparam int IDX_W   = $clog2(N_RINGS),
  localparam int STR_W   = $clog2(N_STREAMS),
  localparam int BSH     = $clog2(BEAT_BYTES),
  localparam int MAX_BTS = PKT_MAX_BYTES / BEAT_BYTES,
  localparam int PKT_W   = $clog2(MAX_BTS + 1),
  localparam int REM_W   = LEN_W - BSH + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_RINGS-1:0]         desc_valid,
  input  logic [N_RINGS*LEN_W-1:0]   desc_bytes,
  output logic [N_RINGS-1:0]         desc_ready,
  input  logic [N_RINGS-1:0]         ring_coll,
  input  logic [N_RINGS*STR_W-1:0]   ring_stream,
  input  logic                       cfg_we,
  input  logic                       cfg_tgt,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [CFG_W-1:0]           cfg_bytes,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       out_last,
  output logic [IDX_W-1:0]           out_ring
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic                          busy_q, busy_d;
  logic [IDX_W-1:0]              cur_q, cur_d;
  logic [IDX_W-1:0]              ptr_q, ptr_d;
  logic [PKT_W-1:0]              left_q, left_d;
  logic                          st_en;
  logic                          pick_any;
  logic [IDX_W-1:0]              pick_idx;
  logic [IDX_W-1:0]              sel;
  logic [N_RINGS-1:0][PKT_W-1:0] size_beats;
  logic [N_RINGS-1:0][REM_W-1:0] rem_beats;
  logic [REM_W-1:0]              rem_sel;
  logic [PKT_W-1:0]              start_len;
  logic [PKT_W-1:0]              left_now;
  logic                          fire;

  rr_picker #(.N_RINGS(N_RINGS)) picker_i (
    .req      (desc_valid),
    .last_idx (ptr_q),
    .pick_any (pick_any),
    .pick_idx (pick_idx)
  );

  pkt_size_regs #(
    .N_RINGS(N_RINGS), .N_STREAMS(N_STREAMS), .CFG_W(CFG_W), .BEAT_BYTES(BEAT_BYTES),
    .CMP_MIN_BYTES(CMP_MIN_BYTES), .PKT_MAX_BYTES(PKT_MAX_BYTES)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cfg_we     (cfg_we),
    .cfg_tgt    (cfg_tgt),
    .cfg_idx    (cfg_idx),
    .cfg_bytes  (cfg_bytes),
    .ring_coll  (ring_coll),
    .ring_stream(ring_stream),
    .size_beats (size_beats)
  );

  ring_progress #(.N_RINGS(N_RINGS), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) prog_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .desc_valid (desc_valid),
    .desc_bytes (desc_bytes),
    .beat_fire  (fire),
    .beat_ring  (sel),
    .rem_beats  (rem_beats)
  );

  assign sel       = busy_q ? cur_q : pick_idx;
  assign rem_sel   = rem_beats[sel];
  assign start_len = (REM_W'(size_beats[sel]) < rem_sel) ? size_beats[sel] : rem_sel[PKT_W-1:0];
  assign left_now  = busy_q ? left_q : start_len;
  assign out_valid = busy_q || pick_any;
  assign out_ring  = sel;
  assign out_last  = out_valid && (left_now == PKT_W'(1));
  assign fire      = out_valid && out_ready;

  for (genvar r = 0; r < N_RINGS; r++) begin : g_rdy
    assign desc_ready[r] = fire && (sel == IDX_W'(r)) && (rem_sel == REM_W'(1));
  end

  always_comb begin
    busy_d = busy_q;
    cur_d  = cur_q;
    ptr_d  = ptr_q;
    left_d = left_q;
    st_en  = 1'b0;
    if (fire) begin
      st_en = 1'b1;
      if (left_now == PKT_W'(1)) begin
        busy_d = 1'b0;
        ptr_d  = sel;
      end else begin
        busy_d = 1'b1;
        cur_d  = sel;
        left_d = left_now - PKT_W'(1);
      end
    end else if (out_valid && !busy_q) begin
      st_en  = 1'b1;
      busy_d = 1'b1;
      cur_d  = sel;
      left_d = left_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      ptr_q  <= '0;
      left_q <= '0;
    end else if (st_en) begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
      ptr_q  <= ptr_d;
      left_q <= left_d;
    end
  end

  // R2
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fire && !out_last) |=> (out_valid && out_ring == $past(out_ring)));

  // R10
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ring) && $stable(out_last)));

  // R7
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(desc_ready));

  // R7
  ready_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|desc_ready) |-> (out_last && out_valid && out_ready));
endmodule

// File: tb/pkt_rr_dma_arb_tb_top.sv
module pkt_rr_dma_arb_tb_top;
  localparam int N = 16;
  localparam int NS = 4;
  localparam int LEN_W = 24;
  localparam int CFG_W = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n;
  logic [N-1:0]         desc_valid;
  logic [N*LEN_W-1:0]   desc_bytes;
  logic [N-1:0]         desc_ready;
  logic [N-1:0]         ring_coll;
  logic [N*2-1:0]       ring_stream;
  logic                 cfg_we;
  logic                 cfg_tgt;
  logic [3:0]           cfg_idx;
  logic [CFG_W-1:0]     cfg_bytes;
  logic                 out_valid;
  logic                 out_ready;
  logic                 out_last;
  logic [3:0]           out_ring;

  pkt_rr_dma_arb dut_i (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_bytes(desc_bytes),
    .desc_ready(desc_ready), .ring_coll(ring_coll), .ring_stream(ring_stream),
    .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_idx(cfg_idx), .cfg_bytes(cfg_bytes),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last), .out_ring(out_ring)
  );

  int unsigned dq[N][$];
  int m_done[N];
  int m_cmp[N];
  int m_str[NS];
  bit m_busy;
  int m_cur, m_left, m_ptr;
  int beats[N], lasts[N], b4[N];
  int checks = 0, errors = 0;
  bit stalled_prev = 0;
  int prev_ring = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int size_of(int r);
    return ring_coll[r] ? m_str[r % NS] : m_cmp[r];
  endfunction

  function automatic int rem_of(int r);
    return (int'(dq[r][0]) + 63) / 64 - m_done[r];
  endfunction

  function automatic int clamp_cmp(int b);
    int v = b / 64;
    if (v < 64) v = 64;
    if (v > 1024) v = 1024;
    return v;
  endfunction

  function automatic int clamp_str(int b);
    int v = b / 64;
    if (v == 0) v = 1;
    if (v > 1024) v = 1024;
    return v;
  endfunction

  function automatic bit pending();
    bit p = m_busy;
    for (int r = 0; r < N; r++) if (dq[r].size() > 0) p = 1;
    return p;
  endfunction

  task automatic drive_desc();
    for (int r = 0; r < N; r++) begin
      desc_valid[r] = dq[r].size() > 0;
      desc_bytes[r*LEN_W +: LEN_W] = (dq[r].size() > 0) ? LEN_W'(dq[r][0]) : '0;
    end
  endtask

  task automatic cyc();
    bit any = 0, ev, fire;
    int sel = 0, left = 0, rm = 0;
    logic [N-1:0] edr;
    @(negedge clk);
    if (m_busy) begin
      sel = m_cur; left = m_left;
    end else begin
      for (int k = 1; k <= N; k++) begin
        int c = (m_ptr + k) % N;
        if (!any && dq[c].size() > 0) begin any = 1; sel = c; end
      end
      if (any) begin
        left = size_of(sel);
        if (rem_of(sel) < left) left = rem_of(sel);
      end
    end
    ev = m_busy || any;
    rm = ev ? rem_of(sel) : 0;
    chk(out_valid == ev, "R3", "out_valid", int'(out_valid), int'(ev));
    if (ev) chk(int'(out_ring) == sel, m_busy ? "R2" : "R1", "out_ring", int'(out_ring), sel);
    if (ev && stalled_prev) chk(int'(out_ring) == prev_ring, "R10", "stalled ring", int'(out_ring), prev_ring);
    chk(out_last == (ev && left == 1), "R8", "out_last", int'(out_last), int'(ev && left == 1));
    edr = (ev && out_ready && rm == 1) ? (N'(1) << sel) : '0;
    chk(desc_ready == edr, "R7", "desc_ready", int'(desc_ready), int'(edr));
    fire = ev && out_ready;
    stalled_prev = ev && !out_ready;
    prev_ring = sel;
    @(posedge clk);
    #1;
    if (cfg_we) begin
      if (cfg_tgt) m_str[cfg_idx] = clamp_str(int'(cfg_bytes));
      else         m_cmp[cfg_idx] = clamp_cmp(int'(cfg_bytes));
    end
    if (fire) begin
      beats[sel]++;
      if (left == 1) begin
        lasts[sel]++;
        if (lasts[sel] == 4) b4[sel] = beats[sel];
        m_busy = 0; m_ptr = sel;
      end else begin
        m_busy = 1; m_cur = sel; m_left = left - 1;
      end
      if (rm == 1) begin m_done[sel] = 0; void'(dq[sel].pop_front()); end
      else m_done[sel]++;
    end else if (ev && !m_busy) begin
      m_busy = 1; m_cur = sel; m_left = left;
    end
    drive_desc();
  endtask

  task automatic cfgw(bit tgt, int idx, int bytes);
    cfg_we = 1; cfg_tgt = tgt; cfg_idx = 4'(idx); cfg_bytes = CFG_W'(bytes);
    cyc();
    cfg_we = 0;
  endtask

  task automatic run_idle();
    int g = 0;
    while (pending() && g < 30000) begin cyc(); g++; end
  endtask

  task automatic clr_counts();
    for (int r = 0; r < N; r++) begin lasts[r] = 0; beats[r] = 0; b4[r] = 0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_tgt = 0; cfg_idx = '0; cfg_bytes = '0; out_ready = 1;
    ring_coll = 16'hFF00;
    for (int r = 0; r < N; r++) ring_stream[r*2 +: 2] = 2'(r % NS);
    for (int r = 0; r < N; r++) begin m_done[r] = 0; m_cmp[r] = 64; end
    for (int s = 0; s < NS; s++) m_str[s] = 1024;
    m_busy = 0; m_cur = 0; m_left = 0; m_ptr = 0;
    clr_counts();
    drive_desc();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R3 reset state
    chk(out_valid == 0, "R3", "reset out_valid", int'(out_valid), 0);
    chk(desc_ready == 0, "R3", "reset desc_ready", int'(desc_ready), 0);
    cyc();

    // R4 R7 R8: 10000 bytes = 157 beats -> 64,64,29
    clr_counts();
    dq[3].push_back(10000); drive_desc();
    run_idle();
    chk(lasts[3] == 3, "R7", "ring3 packets", lasts[3], 3);
    chk(beats[3] == 157, "R7", "ring3 beats", beats[3], 157);

    // R4 clamps
    cfgw(0, 3, 100);
    cfgw(0, 5, 8224);
    cfgw(0, 6, 200000);
    clr_counts();
    dq[3].push_back(8192); dq[5].push_back(8192); dq[6].push_back(100000); drive_desc();
    run_idle();
    chk(lasts[3] == 2, "R4", "min clamp packets", lasts[3], 2);
    chk(lasts[5] == 1, "R4", "rounded size packets", lasts[5], 1);
    chk(lasts[6] == 2, "R4", "max clamp packets", lasts[6], 2);

    // R5 R6 stream registers
    cfgw(1, 1, 100);
    cfgw(1, 2, 0);
    cfgw(1, 3, 100000);
    clr_counts();
    dq[9].push_back(640); dq[13].push_back(320); dq[12].push_back(320);
    dq[10].push_back(200); dq[11].push_back(98304); dq[1].push_back(130); drive_desc();
    run_idle();
    chk(lasts[9] == 10, "R5", "stream1 one-beat packets", lasts[9], 10);
    chk(lasts[10] == 4, "R5", "stream2 zero write", lasts[10], 4);
    chk(lasts[11] == 2, "R5", "stream3 max clamp", lasts[11], 2);
    chk(lasts[13] == 5, "R6", "ring13 uses stream1", lasts[13], 5);
    chk(lasts[12] == 1, "R6", "ring12 uses stream0", lasts[12], 1);
    chk(lasts[1] == 1, "R6", "ring1 uses own register", lasts[1], 1);

    // R9 write mid-packet: 313 beats, first 64 then 128,121
    clr_counts();
    dq[3].push_back(20000); drive_desc();
    repeat (10) cyc();
    cfgw(0, 3, 8192);
    run_idle();
    chk(lasts[3] == 3, "R9", "packets after mid write", lasts[3], 3);
    chk(b4[3] == 0 && beats[3] == 313, "R9", "beats moved", beats[3], 313);

    // R10 random backpressure with mixed rings
    for (int i = 0; i < 3000; i++) begin
      out_ready = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) begin
        int r = $urandom % N;
        if (dq[r].size() < 2) begin dq[r].push_back(1 + $urandom % 5000); drive_desc(); end
      end
      cyc();
    end
    out_ready = 1;
    run_idle();
    chk(!pending(), "R10", "drained after stalls", int'(pending()), 0);

    // R11 bandwidth split 4 KiB vs 64 KiB
    clr_counts();
    begin
      int g = 0;
      while ((lasts[0] < 4 || lasts[8] < 4) && g < 20000) begin
        if (dq[0].size() < 2) dq[0].push_back(16384);
        if (dq[8].size() < 2) dq[8].push_back(65536);
        drive_desc();
        cyc();
        g++;
      end
    end
    chk(b4[0] == 256, "R11", "compute beats at 4 packets", b4[0], 256);
    chk(b4[8] == 16 * b4[0], "R11", "1:16 ratio", b4[8], 16 * b4[0]);
    chk(lasts[0] - lasts[8] <= 1 && lasts[8] - lasts[0] <= 1, "R11", "alternation", lasts[0], lasts[8]);
    run_idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule